// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Per-Bank Row Tracking

This block watches the command pins of a double-data-rate SDRAM device model. On every rising clock edge it samples chip select, the three strobe lines, the bank-select bits and the shared address bus. From these it decodes the command, keeps an open or closed state and the activated row for each bank, and emits a one-cycle read or write request.

Row and column addresses travel on the same pins in two different commands. The block therefore stores the row presented with each activation and combines it with the column presented with the later read or write. Column commands to a bank with no open row, activations of a bank that is already open, and refreshes while any bank is open are all refused, and each raises its own one-cycle error pulse. A mode-register load captures the burst-length field, which is then reported with every request.

All outputs are registered. A command sampled at edge k shows its effect on the outputs just after edge k.

Top module: `dram_cmd_decoder`

## Requirements
- R1: While reset (rst_n low) is applied, every bank is closed, rd_req, wr_req and all three error flags are 0, and req_burst returns to 3'b001.
- R2: ACTIVATE is {cs_n,ras_n,cas_n,we_n}=0,0,1,1. When the addressed bank is closed, ACTIVATE sets bank_open[ba] and stores addr as that bank's row.
- R3: ACTIVATE to an already open bank pulses err_act_open for one cycle and leaves both the open state and the stored row unchanged.
- R4: READ is 0,1,0,1. To an open bank it pulses rd_req for one cycle, with req_bank=ba, req_row equal to the bank's stored row, req_col=addr and req_burst equal to the captured burst field.
- R5: WRITE is 0,1,0,0. To an open bank it pulses wr_req, with the same field rules as R4.
- R6: READ or WRITE to a closed bank pulses err_col_closed and produces no rd_req or wr_req.
- R7: PRECHARGE is 0,0,1,0. With addr[10]=0 it closes only bank ba. With addr[10]=1 it closes every bank. Precharging a closed bank is not an error.
- R8: AUTO REFRESH is 0,0,0,1. It is accepted silently when all banks are closed. With any bank open it pulses err_ref_open, and the bank state is unchanged.
- R9: LOAD MODE is 0,0,0,0. With ba=0 it captures addr[2:0] into req_burst. With any other ba value, req_burst is unchanged.
- R10: cs_n high (deselect), whatever the other pins, and NOP (0,1,1,1) change no state and raise no output pulse.
- R11: At most one of rd_req, wr_req, err_act_open, err_col_closed and err_ref_open is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (13) | Shared row/column/mode address bus |
| rd_req | output | 1 | One-cycle decoded read request |
| wr_req | output | 1 | One-cycle decoded write request |
| req_bank | output | BA_W (2) | Bank of the last request |
| req_row | output | ADDR_W (13) | Row held from activation for the last request |
| req_col | output | ADDR_W (13) | Column of the last request |
| req_burst | output | BL_W (3) | Captured burst-length field |
| bank_open | output | 2**BA_W (4) | Open state per bank, bit i = bank i |
| err_act_open | output | 1 | Activation of an open bank was refused |
| err_col_closed | output | 1 | Column command to a closed bank was refused |
| err_ref_open | output | 1 | Refresh with an open bank was refused |

## Verification
Bank open bits are outputs, so a wrong open/close update appears one cycle after the offending command. A corrupted stored row stays hidden until the next read or write to that bank, where it shows up in req_row. An open bit that is lost or set by mistake is revealed by the next column command or refresh, which either raises a wrong error pulse or drops the request. A burst field captured under the wrong bank select persists, and it shows in req_burst on the next request.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_ACT   = 3'd1,
      CMD_RD    = 3'd2,
      CMD_WR    = 3'd3,
      CMD_PRE   = 3'd4,
      CMD_REF   = 3'd5,
      CMD_MRS   = 3'd6,
      CMD_DESEL = 3'd7
   } cmd_e;

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
   import dram_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;   // 111 NOP, 110 treated as NOP
         endcase
      end
   end

endmodule

// File: rtl/dram_bank_slot.sv
module dram_bank_slot #(
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
      end else if (open_i) begin
         open_o <= 1'b1;
         row_o  <= row_i;
      end else if (close_i) begin
         open_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
   import dram_cmd_pkg::*;
#(
   parameter int             ADDR_W      = 13,
   parameter int             BA_W        = 2,
   parameter int             BL_W        = 3,
   parameter int             PRE_ALL_BIT = 10,
   parameter logic [BL_W-1:0] BL_RESET   = 3'b001
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BA_W-1:0]        ba,
   input  logic [ADDR_W-1:0]      addr,
   output logic                   rd_req,
   output logic                   wr_req,
   output logic [BA_W-1:0]        req_bank,
   output logic [ADDR_W-1:0]      req_row,
   output logic [ADDR_W-1:0]      req_col,
   output logic [BL_W-1:0]        req_burst,
   output logic [(1<<BA_W)-1:0]   bank_open,
   output logic                   err_act_open,
   output logic                   err_col_closed,
   output logic                   err_ref_open
);

   localparam int N_BANK = 1 << BA_W;

   // elaboration-time parameter checks
   if (PRE_ALL_BIT >= ADDR_W) begin : g_bad_pre
      $error("PRE_ALL_BIT must lie inside the address bus");
   end
   if (BL_W > ADDR_W) begin : g_bad_bl
      $error("burst field wider than the address bus");
   end
   if (BA_W < 1) begin : g_bad_ba
      $error("at least one bank-select bit is needed");
   end

   cmd_e              cmd;
   logic [ADDR_W-1:0] row_q [N_BANK];
   logic              sel_open;

   dram_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign sel_open = bank_open[ba];

   for (genvar gi = 0; gi < N_BANK; gi++) begin : g_bank
      logic hit;
      logic do_open;
      logic do_close;
      assign hit      = (ba == BA_W'(gi));
      assign do_open  = (cmd == CMD_ACT) && hit && !sel_open;
      assign do_close = (cmd == CMD_PRE) && (hit || addr[PRE_ALL_BIT]);

      dram_bank_slot #(.ROW_W(ADDR_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_i  (do_open),
         .close_i (do_close),
         .row_i   (addr),
         .open_o  (bank_open[gi]),
         .row_o   (row_q[gi])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_req         <= 1'b0;
         wr_req         <= 1'b0;
         req_bank       <= '0;
         req_row        <= '0;
         req_col        <= '0;
         req_burst      <= BL_RESET;
         err_act_open   <= 1'b0;
         err_col_closed <= 1'b0;
         err_ref_open   <= 1'b0;
      end else begin
         rd_req         <= 1'b0;
         wr_req         <= 1'b0;
         err_act_open   <= 1'b0;
         err_col_closed <= 1'b0;
         err_ref_open   <= 1'b0;
         case (cmd)
            CMD_ACT: begin
               if (sel_open) err_act_open <= 1'b1;
            end
            CMD_RD, CMD_WR: begin
               if (!sel_open) begin
                  err_col_closed <= 1'b1;
               end else begin
                  rd_req   <= (cmd == CMD_RD);
                  wr_req   <= (cmd == CMD_WR);
                  req_bank <= ba;
                  req_row  <= row_q[ba];
                  req_col  <= addr;
               end
            end
            CMD_REF: begin
               if (|bank_open) err_ref_open <= 1'b1;
            end
            CMD_MRS: begin
               if (ba == '0) req_burst <= addr[BL_W-1:0];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker #(
   parameter int BA_W = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic                 pre_all,
   input logic                 rd_req,
   input logic                 wr_req,
   input logic [BA_W-1:0]      req_bank,
   input logic [(1<<BA_W)-1:0] bank_open,
   input logic                 err_act_open,
   input logic                 err_col_closed,
   input logic                 err_ref_open
);

   logic pre_cmd;
   assign pre_cmd = !cs_n && !ras_n && cas_n && !we_n;

   // R11
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, wr_req, err_act_open, err_col_closed, err_ref_open}));

   // R4
   rd_bank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> bank_open[req_bank]);

   // R5
   wr_bank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> bank_open[req_bank]);

   // R3
   act_err_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_act_open |-> $stable(bank_open));

   // R8
   ref_err_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_ref_open |-> (bank_open != '0) && $stable(bank_open));

   // R7
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pre_cmd && pre_all)) |-> (bank_open == '0));

endmodule

bind dram_cmd_decoder dram_cmd_checker #(.BA_W(BA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_n           (cs_n),
   .ras_n          (ras_n),
   .cas_n          (cas_n),
   .we_n           (we_n),
   .pre_all        (addr[PRE_ALL_BIT]),
   .rd_req         (rd_req),
   .wr_req         (wr_req),
   .req_bank       (req_bank),
   .bank_open      (bank_open),
   .err_act_open   (err_act_open),
   .err_col_closed (err_col_closed),
   .err_ref_open   (err_ref_open)
);

// File: tb/sim_dram_cmd_decoder.sv
`timescale 1ns/1ps
module sim_dram_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic        rd_req, wr_req, err_act_open, err_col_closed, err_ref_open;
   logic [1:0]  req_bank;
   logic [12:0] req_row, req_col;
   logic [2:0]  req_burst;
   logic [3:0]  bank_open;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   dram_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .rd_req(rd_req), .wr_req(wr_req),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_burst(req_burst), .bank_open(bank_open),
      .err_act_open(err_act_open), .err_col_closed(err_col_closed),
      .err_ref_open(err_ref_open)
   );

   // {cs,ras,cas,we}
   localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                          WR = 4'b0100, PRE = 4'b0010, REF = 4'b0001,
                          MRS = 4'b0000, DES = 4'b1000;

   typedef struct packed {
      logic [3:0]  c;
      logic [1:0]  ba;
      logic [12:0] a;
      logic [4:0]  f;     // {rd, wr, err_act, err_col, err_ref}
      logic [3:0]  op;
      logic [12:0] row;
      logic [2:0]  bl;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{NOP, 2'd0, 13'h0000, 5'b00000, 4'b0000, 13'h0000, 3'b001, 8'd10}, // R10
      '{RD,  2'd0, 13'h0005, 5'b00010, 4'b0000, 13'h0000, 3'b001, 8'd6 }, // R6
      '{ACT, 2'd0, 13'h0123, 5'b00000, 4'b0001, 13'h0000, 3'b001, 8'd2 }, // R2
      '{ACT, 2'd2, 13'h00AA, 5'b00000, 4'b0101, 13'h0000, 3'b001, 8'd2 }, // R2
      '{RD,  2'd0, 13'h0010, 5'b10000, 4'b0101, 13'h0123, 3'b001, 8'd4 }, // R4
      '{WR,  2'd2, 13'h0007, 5'b01000, 4'b0101, 13'h00AA, 3'b001, 8'd5 }, // R5
      '{ACT, 2'd0, 13'h01FF, 5'b00100, 4'b0101, 13'h0000, 3'b001, 8'd3 }, // R3
      '{RD,  2'd0, 13'h0001, 5'b10000, 4'b0101, 13'h0123, 3'b001, 8'd3 }, // R3 row kept
      '{REF, 2'd0, 13'h0000, 5'b00001, 4'b0101, 13'h0000, 3'b001, 8'd8 }, // R8
      '{DES, 2'd0, 13'h0003, 5'b00000, 4'b0101, 13'h0000, 3'b001, 8'd10}, // R10
      '{PRE, 2'd0, 13'h0000, 5'b00000, 4'b0100, 13'h0000, 3'b001, 8'd7 }, // R7
      '{WR,  2'd0, 13'h0002, 5'b00010, 4'b0100, 13'h0000, 3'b001, 8'd6 }, // R6
      '{ACT, 2'd1, 13'h0055, 5'b00000, 4'b0110, 13'h0000, 3'b001, 8'd2 }, // R2
      '{PRE, 2'd3, 13'h0400, 5'b00000, 4'b0000, 13'h0000, 3'b001, 8'd7 }, // R7
      '{REF, 2'd0, 13'h0000, 5'b00000, 4'b0000, 13'h0000, 3'b001, 8'd8 }, // R8
      '{MRS, 2'd1, 13'h0007, 5'b00000, 4'b0000, 13'h0000, 3'b001, 8'd9 }, // R9
      '{MRS, 2'd0, 13'h0003, 5'b00000, 4'b0000, 13'h0000, 3'b011, 8'd9 }, // R9
      '{ACT, 2'd3, 13'h1ABC, 5'b00000, 4'b1000, 13'h0000, 3'b011, 8'd2 }, // R2
      '{RD,  2'd3, 13'h1FFF, 5'b10000, 4'b1000, 13'h1ABC, 3'b011, 8'd4 }  // R4
   };

   task automatic chk(input bit ok, input int rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b;
      addr = a;
   endtask

   logic [4:0] flags;
   assign flags = {rd_req, wr_req, err_act_open, err_col_closed, err_ref_open};

   initial begin
      #(8 * 5000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      drive(NOP, 2'd0, 13'h0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bank_open == 4'b0 && flags == 5'b0 && req_burst == 3'b001, 1,
          "reset state", {21'b0, bank_open, flags, req_burst}, 32'h1);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].c, VEC[i].ba, VEC[i].a);
         @(negedge clk);
         chk(flags == VEC[i].f, VEC[i].rq, $sformatf("flags vec%0d", i),
             32'(flags), 32'(VEC[i].f));
         chk(bank_open == VEC[i].op, VEC[i].rq, $sformatf("bank_open vec%0d", i),
             32'(bank_open), 32'(VEC[i].op));
         chk(req_burst == VEC[i].bl, VEC[i].rq, $sformatf("burst vec%0d", i),
             32'(req_burst), 32'(VEC[i].bl));
         // R11 single event per cycle
         chk($countones(flags) <= 1, 11, $sformatf("one event vec%0d", i),
             32'(flags), 32'(VEC[i].f));
         if (VEC[i].f[4] || VEC[i].f[3]) begin
            chk(req_bank == VEC[i].ba && req_row == VEC[i].row && req_col == VEC[i].a,
                VEC[i].rq, $sformatf("req fields vec%0d", i),
                {4'b0, req_bank, req_row, req_col}, {4'b0, VEC[i].ba, VEC[i].row, VEC[i].a});
         end
      end

      // R1 reset while a bank is open and burst is non-default
      drive(NOP, 2'd0, 13'h0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(bank_open == 4'b0 && req_burst == 3'b001 && flags == 5'b0, 1,
          "mid-run reset", {21'b0, bank_open, flags, req_burst}, 32'h1);
      rst_n = 1'b1;
      // R6 bank 3 closed after reset: read must be refused
      drive(RD, 2'd3, 13'h0004);
      @(negedge clk);
      chk(flags == 5'b00010, 6, "read after reset", 32'(flags), 32'h2);
      drive(NOP, 2'd0, 13'h0);
      @(negedge clk);
      chk(flags == 5'b0, 10, "nop quiet", 32'(flags), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule